// File: doc/BRIEF.md
# Coprocessor return FIFO with single-byte forward register

This block carries the first channel of a byte link between a host processor and an attached coprocessor. Bytes going from the coprocessor to the host are queued in a 24-entry FIFO. This lets the coprocessor stream a burst of characters without waiting for the host to read each one. Bytes going the other way pass through a single holding register.

Each side sees an 8-bit status byte. Bit 7 means data is waiting for that side to read. Bit 6 means that side may write. Bits 5 to 0 always read as zero. When the host reads the FIFO while it is empty, it gets the last byte the coprocessor wrote to any channel. The block keeps that byte from the coprocessor write strobe. The two data-available flags also appear as separate outputs for the interrupt logic next to the block.

Top module: `cop_link_ch1`

## Requirements
- R1: After reset, host_stat and cop_stat both read 0x40, and host_rdata reads 0x00.
- R2: Bytes pushed by coprocessor writes with cop_wr_fifo set are returned by host reads in the order written. This holds across pointer wrap, with head and tail wrapping from entry 23 to entry 0.
- R3: A FIFO push while the FIFO holds 24 bytes is discarded, even in a cycle that also pops. It changes no stored byte and no count.
- R4: host_stat bit 7 (and host_dav) is 1 whenever the FIFO holds at least one byte. cop_stat bit 6 is 0 exactly when the FIFO holds 24 bytes.
- R5: A host read from a non-empty FIFO removes the head byte and leaves cop_stat bit 6 at 1. host_stat bit 7 clears when the last byte is removed.
- R6: A host read from an empty FIFO returns the byte from the most recent cop_wr on any channel, whether or not cop_wr_fifo was set. It leaves the FIFO empty and the status unchanged.
- R7: host_wr stores host_wdata on cop_rdata, sets cop_stat bit 7 (cop_dav) and clears host_stat bit 6. A later cop_rd clears cop_stat bit 7 and sets host_stat bit 6. A host_wr in the same cycle as cop_rd takes priority.
- R8: A push and a pop in the same cycle on a FIFO that is neither empty nor full keep the count unchanged. The popped byte is the old head.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cop_wr | input | 1 | Coprocessor write strobe on any channel; loads the empty-read latch |
| cop_wr_fifo | input | 1 | Qualifies cop_wr as a push into this channel's FIFO |
| cop_wdata | input | 8 | Coprocessor write data |
| cop_rd | input | 1 | Coprocessor read strobe of the forward register |
| cop_rdata | output | 8 | Forward register contents |
| host_rd | input | 1 | Host read strobe of the FIFO |
| host_rdata | output | 8 | FIFO head byte, or the latched byte when the FIFO is empty |
| host_wr | input | 1 | Host write strobe of the forward register |
| host_wdata | input | 8 | Host write data |
| host_stat | output | 8 | Host status: bit 7 data available, bit 6 space available |
| cop_stat | output | 8 | Coprocessor status: bit 7 data available, bit 6 space available |
| host_dav | output | 1 | Host data-available flag for interrupt logic |
| cop_dav | output | 1 | Coprocessor data-available flag for interrupt logic |

## Verification
The assertions assume that cop_wr_fifo is only raised together with cop_wr, because a push is by definition a coprocessor write; one assertion checks this on the inputs. The bench keeps to this rule by raising both strobes in the same cycle for every push. It raises cop_wr alone for writes that only load the latch. Strobes last one cycle and change on the falling edge. Reads therefore sample the combinational read data before the rising edge that acts on them.

// File: rtl/cop_link_ch1.sv
module cop_link_ch1 #(
  parameter int DEPTH = 24,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cop_wr,
  input  logic         cop_wr_fifo,
  input  logic [W-1:0] cop_wdata,
  input  logic         cop_rd,
  output logic [W-1:0] cop_rdata,
  input  logic         host_rd,
  output logic [W-1:0] host_rdata,
  input  logic         host_wr,
  input  logic [W-1:0] host_wdata,
  output logic [7:0]   host_stat,
  output logic [7:0]   cop_stat,
  output logic         host_dav,
  output logic         cop_dav
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;
  logic [W-1:0]  last_q, fwd_q;
  logic          fwd_full;

  wire empty = (count == '0);
  wire full  = (count == FULLC);
  wire push  = cop_wr & cop_wr_fifo & ~full;
  wire pop   = host_rd & ~empty;

  always_ff @(posedge clk)
    if (push) mem[tail] <= cop_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      tail     <= '0;
      count    <= '0;
      last_q   <= '0;
      fwd_q    <= '0;
      fwd_full <= 1'b0;
    end else begin
      if (push) tail <= (tail == LASTP) ? '0 : tail + 1'b1;
      if (pop)  head <= (head == LASTP) ? '0 : head + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (cop_wr) last_q <= cop_wdata;
      if (host_wr) begin
        fwd_q    <= host_wdata;
        fwd_full <= 1'b1;
      end else if (cop_rd) begin
        fwd_full <= 1'b0;
      end
    end
  end

  assign host_rdata = empty ? last_q : mem[head];
  assign cop_rdata  = fwd_q;
  assign host_dav   = ~empty;
  assign cop_dav    = fwd_full;
  assign host_stat  = {host_dav, ~fwd_full, 6'b0};
  assign cop_stat   = {cop_dav, ~full, 6'b0};

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLC);
  // R3
  full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_wr && cop_wr_fifo && full && !host_rd) |=> (full && $stable(tail)));
  // R8
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_wr && cop_wr_fifo && host_rd && !empty && !full) |=> $stable(count));
  // R5
  pop_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !empty) |=> cop_stat[6]);
  // R6
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && empty && !(cop_wr && cop_wr_fifo)) |=> (!host_dav && $stable(head)));
  // R7
  fwd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (cop_stat[7] && !host_stat[6] && cop_rdata == $past(host_wdata)));
  // R7
  fwd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_rd && !host_wr) |=> (!cop_dav && host_stat[6]));
  // R6
  push_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_wr_fifo |-> cop_wr);
endmodule

// File: tb/sim_cop_link_ch1.sv
module sim_cop_link_ch1;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cop_wr = 0, cop_wr_fifo = 0, cop_rd = 0, host_rd = 0, host_wr = 0;
  logic [7:0] cop_wdata = 0, host_wdata = 0;
  logic [7:0] cop_rdata, host_rdata, host_stat, cop_stat;
  logic host_dav, cop_dav;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cop_link_ch1 u0 (
    .clk(clk), .rst_n(rst_n),
    .cop_wr(cop_wr), .cop_wr_fifo(cop_wr_fifo), .cop_wdata(cop_wdata),
    .cop_rd(cop_rd), .cop_rdata(cop_rdata),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .host_wr(host_wr), .host_wdata(host_wdata),
    .host_stat(host_stat), .cop_stat(cop_stat),
    .host_dav(host_dav), .cop_dav(cop_dav)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // op: 0 push, 1 host read, 2 host write, 3 coprocessor read
  // fields: op, data, expected read byte, expected host_stat, expected cop_stat
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 8'h11, 8'h00, 8'hC0, 8'h40},
    {2'd0, 8'h22, 8'h00, 8'hC0, 8'h40},
    {2'd1, 8'h00, 8'h11, 8'hC0, 8'h40},
    {2'd1, 8'h00, 8'h22, 8'h40, 8'h40},
    {2'd1, 8'h00, 8'h22, 8'h40, 8'h40},
    {2'd2, 8'h5A, 8'h00, 8'h00, 8'hC0},
    {2'd3, 8'h00, 8'h5A, 8'h40, 8'h40},
    {2'd0, 8'h77, 8'h00, 8'hC0, 8'h40},
    {2'd2, 8'h3C, 8'h00, 8'h80, 8'hC0},
    {2'd1, 8'h00, 8'h77, 8'h00, 8'hC0},
    {2'd3, 8'h00, 8'h3C, 8'h40, 8'h40},
    {2'd1, 8'h00, 8'h77, 8'h40, 8'h40}
  };

  task automatic idle();
    @(negedge clk);
    cop_wr = 0; cop_wr_fifo = 0; cop_rd = 0; host_rd = 0; host_wr = 0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    cop_wr = 1; cop_wr_fifo = 1; cop_wdata = d;
    idle();
  endtask

  task automatic pop_chk(input string tag, input logic [7:0] exp);
    @(negedge clk);
    host_rd = 1;
    #1 chk(tag, host_rdata, exp);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 host_stat", host_stat, 8'h40);
    chk("R1 cop_stat", cop_stat, 8'h40);
    chk("R1 host_rdata", host_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cop_wdata = VEC[i][31:24];
      host_wdata = VEC[i][31:24];
      case (VEC[i][33:32])
        2'd0: begin cop_wr = 1; cop_wr_fifo = 1; end
        2'd1: host_rd = 1;
        2'd2: host_wr = 1;
        default: cop_rd = 1;
      endcase
      #1;
      if (VEC[i][33:32] == 2'd1) chk("R2/R6 vector read", host_rdata, VEC[i][23:16]);
      if (VEC[i][33:32] == 2'd3) chk("R7 vector cop_rdata", cop_rdata, VEC[i][23:16]);
      idle();
      chk("R4/R5/R7 vector host_stat", host_stat, VEC[i][15:8]);
      chk("R4/R5/R7 vector cop_stat", cop_stat, VEC[i][7:0]);
    end

    // R6: write on another channel loads the latch only
    @(negedge clk);
    cop_wr = 1; cop_wdata = 8'h9E;
    idle();
    chk("R6 other-channel write leaves FIFO empty", host_stat, 8'h40);
    pop_chk("R6 empty read returns latch", 8'h9E);
    chk("R6 empty read status", host_stat, 8'h40);

    // R2: move pointers, then fill across the wrap point
    for (int i = 0; i < 10; i++) begin
      push(8'(i));
      pop_chk("R2 pre-wrap order", 8'(i));
    end
    for (int i = 0; i < 24; i++) begin
      push(8'(8'hA0 + i));
      if (i == 22) chk("R4 space at 23 entries", cop_stat, 8'h40);
    end
    chk("R4 full clears cop space", cop_stat, 8'h00);
    chk("R4 full host data", host_stat, 8'hC0);
    push(8'hFF);
    chk("R3 overrun keeps full", cop_stat, 8'h00);
    for (int i = 0; i < 24; i++) begin
      pop_chk("R2 wrapped order", 8'(8'hA0 + i));
      if (i == 0) chk("R5 pop restores cop space", cop_stat, 8'h40);
    end
    chk("R5 drained clears host data", host_stat, 8'h40);
    pop_chk("R3 overrun byte never stored", 8'hFF);
    chk("R3 still empty", host_stat, 8'h40);

    // R3: full with simultaneous push and pop
    for (int i = 0; i < 24; i++) push(8'(8'h40 + i));
    @(negedge clk);
    cop_wr = 1; cop_wr_fifo = 1; cop_wdata = 8'hEE; host_rd = 1;
    #1 chk("R3 pop at full returns head", host_rdata, 8'h40);
    idle();
    chk("R3 pop at full frees one slot", cop_stat, 8'h40);
    for (int i = 1; i < 24; i++) pop_chk("R3 push at full dropped", 8'(8'h40 + i));
    chk("R3 empty after 23 pops", host_stat, 8'h40);

    // R8: simultaneous push and pop with one entry
    push(8'hA1);
    @(negedge clk);
    cop_wr = 1; cop_wr_fifo = 1; cop_wdata = 8'hB2; host_rd = 1;
    #1 chk("R8 simultaneous pop returns old head", host_rdata, 8'hA1);
    idle();
    chk("R8 level kept", host_stat, 8'hC0);
    pop_chk("R8 pushed byte follows", 8'hB2);
    chk("R8 empty after", host_stat, 8'h40);

    // R7: host write and coprocessor read in one cycle
    @(negedge clk);
    host_wr = 1; cop_rd = 1; host_wdata = 8'h66;
    idle();
    chk("R7 write wins cop_stat", cop_stat, 8'hC0);
    chk("R7 write wins cop_rdata", cop_rdata, 8'h66);

    // R1: reset again
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 reset host_stat", host_stat, 8'h40);
    chk("R1 reset cop_stat", cop_stat, 8'h40);
    chk("R1 reset latch", host_rdata, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule